// File: doc/BRIEF.md
# Register Vector Mode Tag Tracker

This block holds a small mode tag for every integer register encoding and keeps those tags current as instructions retire. Each tag says whether the value in that register is a scalar or a vector (plain or predicated) and how many elements make up one sub-vector. When an instruction carries an explicit mode, that mode is stored into the destination's tag. Otherwise the result mode is worked out from the tags of the source operands it reads. The tags therefore travel through a program the way the values do, and vector mode does not have to be re-stated on every instruction.

Two source operands whose sub-vector lengths disagree are an error, unless the instruction declares that it can handle mixed lengths. For such an instruction the block reports an illegal-instruction trap and leaves every tag unchanged. Trap entry copies all tags into a shadow copy and returns the live tags to all-scalar. Trap return copies the shadow back. A separate clear command also returns all tags to all-scalar. Software reads and writes the whole tag state as a row of XLEN-wide chunks. Instructions are offered one per cycle on a valid/ready handshake. Any command (trap entry, trap return, clear, chunk write) takes that cycle, and no instruction is accepted in it.

Top module: `vmode_tag_tracker`

## Requirements
- R1: After reset every tag is zero, `in_ready` is high and `illegal_o` is low.
- R2: The tag of register i occupies bits [4i+3:4i] of the flattened state, and chunk k is state bits [XLEN*k+XLEN-1 : XLEN*k]. `csr_rdata` shows the chunk picked by `csr_sel` in the same cycle. A `csr_we` cycle loads that chunk into the state at the clock edge.
- R3: A tag holds the element-group size in bits 1:0 (00=1, 01=2, 10=3, 11=4) and the kind in bits 3:2 (00=scalar, 01=vector, 1x=predicated vector). An accepted instruction with `in_has_prefix` high stores `in_prefix_tag` into the destination tag unchanged, and it never traps, even when its sources disagree.
- R4: Without a prefix, the stored kind is predicated (10) if any used source is predicated. Otherwise it is vector (01) if any used source is a vector, and scalar (00) in all other cases. The group size is that of the single used source, the common size when both sources are used, or 00 when no source is used.
- R5: Without a prefix, two used sources with different group sizes and `in_mixed_ok` low raise `illegal_o` for the one cycle after acceptance, and no tag changes.
- R6: When `in_mixed_ok` is high, differing group sizes raise no trap, and the result takes the larger of the two sizes.
- R7: The tag of register 0 always reads as zero. Instruction writes to it and chunk writes to its bits have no effect.
- R8: `trap_enter` copies all live tags into the shadow copy and sets every live tag to zero in the same edge.
- R9: `trap_return` loads the live tags from the shadow copy. Tags written between entry and return are lost.
- R10: `clear_cmd` sets every live tag to zero.
- R11: While any command input is high, `in_ready` is low and an offered instruction updates no tag.
- R12: A source whose `used` flag is low adds nothing to the mode and cannot cause a group-size trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Retiring instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_has_prefix | input | 1 | Instruction carries an explicit mode |
| in_prefix_tag | input | 4 | Explicit mode tag |
| in_rd | input | clog2(NREG) | Destination register encoding |
| in_rs1 | input | clog2(NREG) | First source encoding |
| in_rs1_used | input | 1 | First source is read |
| in_rs2 | input | clog2(NREG) | Second source encoding |
| in_rs2_used | input | 1 | Second source is read |
| in_mixed_ok | input | 1 | Instruction handles differing group sizes |
| illegal_o | output | 1 | Group-size trap, one cycle after acceptance |
| trap_enter | input | 1 | Save tags to shadow and clear |
| trap_return | input | 1 | Restore tags from shadow |
| clear_cmd | input | 1 | Zero all tags |
| csr_sel | input | sel_w | Chunk index |
| csr_we | input | 1 | Write selected chunk |
| csr_wdata | input | XLEN | Chunk write data |
| csr_rdata | output | XLEN | Selected chunk read data |

## Verification
The hardest state to reach is a set of live tags in which several registers hold different kinds and group sizes at once. Only then can propagation, predication priority and the group-size trap be told apart. The stimulus builds that state in one chunk write, then walks a table of instructions whose destinations fill a second chunk. A trap taken with both chunks populated, followed by a write during the trap, shows that the restore brings back exactly the saved state.

// File: rtl/vmtag_pkg.sv
package vmtag_pkg;
   localparam int TAG_W = 4;
   typedef logic [TAG_W-1:0] vtag_t;
   localparam logic [1:0] KIND_SCALAR = 2'b00;
   localparam logic [1:0] KIND_VEC    = 2'b01;
   localparam logic [1:0] KIND_PRED   = 2'b10;

   function automatic int sel_w(input int nreg, input int xlen);
      int n;
      n = (nreg * TAG_W) / xlen;
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/vmtag_resolve.sv
module vmtag_resolve
   import vmtag_pkg::*;
(
   input  vtag_t tag_a,
   input  logic  use_a,
   input  vtag_t tag_b,
   input  logic  use_b,
   input  logic  has_prefix,
   input  vtag_t prefix_tag,
   input  logic  mixed_ok,
   output vtag_t res_tag,
   output logic  mismatch
);
   logic       vec_any, pred_any, both, differ;
   logic [1:0] grp, kind;

   always_comb begin
      pred_any = (use_a && tag_a[3]) || (use_b && tag_b[3]);
      vec_any  = (use_a && (tag_a[3:2] != 2'b00)) || (use_b && (tag_b[3:2] != 2'b00));
      both     = use_a && use_b;
      differ   = both && (tag_a[1:0] != tag_b[1:0]);
      if (both)       grp = (tag_a[1:0] > tag_b[1:0]) ? tag_a[1:0] : tag_b[1:0];
      else if (use_a) grp = tag_a[1:0];
      else if (use_b) grp = tag_b[1:0];
      else            grp = 2'b00;
      if (pred_any)     kind = KIND_PRED;
      else if (vec_any) kind = KIND_VEC;
      else              kind = KIND_SCALAR;
      res_tag  = has_prefix ? prefix_tag : {kind, grp};
      mismatch = !has_prefix && differ && !mixed_ok;
   end
endmodule

// File: rtl/vmtag_store.sv
module vmtag_store
   import vmtag_pkg::*;
#(
   parameter int NREG = 32,
   parameter int XLEN = 32,
   localparam int IDX_W   = $clog2(NREG),
   localparam int STATE_W = NREG * TAG_W,
   localparam int SEL_W   = sel_w(NREG, XLEN)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_enter,
   input  logic               trap_return,
   input  logic               clear_cmd,
   input  logic               csr_we,
   input  logic [SEL_W-1:0]   csr_sel,
   input  logic [XLEN-1:0]    csr_wdata,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  vtag_t              wr_tag,
   input  logic [IDX_W-1:0]   rd_idx_a,
   input  logic [IDX_W-1:0]   rd_idx_b,
   output vtag_t              rd_tag_a,
   output vtag_t              rd_tag_b,
   output logic [STATE_W-1:0] state_flat
);
   vtag_t              live_q   [NREG];
   vtag_t              shadow_q [NREG];
   logic [STATE_W-1:0] shadow_flat;

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         localparam int CHUNK = (i * TAG_W) / XLEN;
         localparam int OFF   = (i * TAG_W) % XLEN;
         if (i == 0) begin : g_zero
            always_ff @(posedge clk) live_q[i] <= '0;
         end else begin : g_live
            always_ff @(posedge clk) begin
               if (!rst_n)                                           live_q[i] <= '0;
               else if (trap_enter)                                  live_q[i] <= '0;
               else if (trap_return)                                 live_q[i] <= shadow_q[i];
               else if (clear_cmd)                                   live_q[i] <= '0;
               else if (csr_we && (csr_sel == SEL_W'(CHUNK)))        live_q[i] <= csr_wdata[OFF +: TAG_W];
               else if (wr_en && (wr_idx == IDX_W'(i)))              live_q[i] <= wr_tag;
            end
         end
         always_ff @(posedge clk) begin
            if (!rst_n)          shadow_q[i] <= '0;
            else if (trap_enter) shadow_q[i] <= live_q[i];
         end
         assign state_flat[i*TAG_W +: TAG_W]  = live_q[i];
         assign shadow_flat[i*TAG_W +: TAG_W] = shadow_q[i];
      end
   endgenerate

   assign rd_tag_a = live_q[rd_idx_a];
   assign rd_tag_b = live_q[rd_idx_b];

   assert_x0_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      state_flat[TAG_W-1:0] == '0);
   assert_trap_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter |=> state_flat == '0);
   assert_trap_saves_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter |=> shadow_flat == $past(state_flat));
   assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_return && !trap_enter) |=> state_flat == $past(shadow_flat));
   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_cmd && !trap_enter && !trap_return) |=> state_flat == '0);
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != '0 && !trap_enter && !trap_return && !clear_cmd && !csr_we)
      |=> live_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/vmtag_csr_port.sv
module vmtag_csr_port
   import vmtag_pkg::*;
#(
   parameter int NREG = 32,
   parameter int XLEN = 32,
   localparam int STATE_W = NREG * TAG_W,
   localparam int NCHUNK  = STATE_W / XLEN,
   localparam int SEL_W   = sel_w(NREG, XLEN)
)(
   input  logic [STATE_W-1:0] state_flat,
   input  logic [SEL_W-1:0]   csr_sel,
   output logic [XLEN-1:0]    csr_rdata
);
   always_comb begin
      csr_rdata = '0;
      for (int k = 0; k < NCHUNK; k++) begin
         if (csr_sel == SEL_W'(k)) csr_rdata = state_flat[k*XLEN +: XLEN];
      end
   end
endmodule

// File: rtl/vmode_tag_tracker.sv
module vmode_tag_tracker
   import vmtag_pkg::*;
#(
   parameter int NREG = 32,
   parameter int XLEN = 32
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   output logic                            in_ready,
   input  logic                            in_has_prefix,
   input  logic [3:0]                      in_prefix_tag,
   input  logic [$clog2(NREG)-1:0]         in_rd,
   input  logic [$clog2(NREG)-1:0]         in_rs1,
   input  logic                            in_rs1_used,
   input  logic [$clog2(NREG)-1:0]         in_rs2,
   input  logic                            in_rs2_used,
   input  logic                            in_mixed_ok,
   output logic                            illegal_o,
   input  logic                            trap_enter,
   input  logic                            trap_return,
   input  logic                            clear_cmd,
   input  logic [sel_w(NREG, XLEN)-1:0]    csr_sel,
   input  logic                            csr_we,
   input  logic [XLEN-1:0]                 csr_wdata,
   output logic [XLEN-1:0]                 csr_rdata
);
   localparam int STATE_W = NREG * TAG_W;

   generate
      if (STATE_W % XLEN != 0) begin : g_bad_xlen
         $error("tag state width must split into whole XLEN chunks");
      end
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("register count must be a power of two of at least 2");
      end
   endgenerate

   logic               cmd_busy, accept, mismatch, wr_en, illegal_q;
   vtag_t              tag_a, tag_b, res_tag;
   logic [STATE_W-1:0] state_flat;

   assign cmd_busy = trap_enter | trap_return | clear_cmd | csr_we;
   assign in_ready = !cmd_busy;
   assign accept   = in_valid && in_ready;
   assign wr_en    = accept && !mismatch;

   vmtag_resolve u_resolve (
      .tag_a(tag_a), .use_a(in_rs1_used),
      .tag_b(tag_b), .use_b(in_rs2_used),
      .has_prefix(in_has_prefix), .prefix_tag(in_prefix_tag),
      .mixed_ok(in_mixed_ok), .res_tag(res_tag), .mismatch(mismatch)
   );

   vmtag_store #(.NREG(NREG), .XLEN(XLEN)) u_store (
      .clk(clk), .rst_n(rst_n),
      .trap_enter(trap_enter), .trap_return(trap_return), .clear_cmd(clear_cmd),
      .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
      .wr_en(wr_en), .wr_idx(in_rd), .wr_tag(res_tag),
      .rd_idx_a(in_rs1), .rd_idx_b(in_rs2),
      .rd_tag_a(tag_a), .rd_tag_b(tag_b),
      .state_flat(state_flat)
   );

   vmtag_csr_port #(.NREG(NREG), .XLEN(XLEN)) u_csr (
      .state_flat(state_flat), .csr_sel(csr_sel), .csr_rdata(csr_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) illegal_q <= 1'b0;
      else        illegal_q <= accept && mismatch;
   end
   assign illegal_o = illegal_q;

   assert_illegal_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cmd_busy && !in_has_prefix && in_rs1_used && in_rs2_used && !in_mixed_ok
       && tag_a[1:0] != tag_b[1:0]) |=> illegal_o);
   assert_trap_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && mismatch) |=> $stable(state_flat));
   assert_busy_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && !trap_enter && !trap_return && !clear_cmd && in_valid)
      |=> !illegal_o);
   assert_prefix_no_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_has_prefix) |=> !illegal_o);
endmodule

// File: tb/vmode_tag_tracker_bench.sv
module vmode_tag_tracker_bench;
   import vmtag_pkg::*;
   localparam int NREG = 32;
   localparam int XLEN = 32;
   localparam int SEL_W = sel_w(NREG, XLEN);

   typedef struct packed {
      logic       pre;
      logic [3:0] ptag;
      logic [4:0] rd;
      logic [4:0] rs1;
      logic       u1;
      logic [4:0] rs2;
      logic       u2;
      logic       mix;
      logic       exp_ill;
      logic [3:0] exp_tag;
   } vec_t;

   // initial chunk 0: x1=5 x2=1 x3=4 x4=9 x5=B x6=6 x7=0 (x0 write of F ignored)
   localparam vec_t VECS [11] = '{
      '{1'b1, 4'hE, 5'd8,  5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 4'hE}, // R3
      '{1'b0, 4'h0, 5'd9,  5'd1, 1'b1, 5'd2, 1'b1, 1'b0, 1'b0, 4'h5}, // R4
      '{1'b0, 4'h0, 5'd10, 5'd3, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 4'h4}, // R4
      '{1'b0, 4'h0, 5'd11, 5'd4, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0, 4'h9}, // R4 predicated
      '{1'b0, 4'h0, 5'd12, 5'd2, 1'b1, 5'd6, 1'b0, 1'b0, 1'b0, 4'h1}, // R12
      '{1'b0, 4'h0, 5'd13, 5'd1, 1'b1, 5'd6, 1'b1, 1'b0, 1'b1, 4'h0}, // R5
      '{1'b0, 4'h0, 5'd13, 5'd1, 1'b1, 5'd6, 1'b1, 1'b1, 1'b0, 4'h6}, // R6
      '{1'b1, 4'h3, 5'd14, 5'd5, 1'b1, 5'd4, 1'b1, 1'b0, 1'b0, 4'h3}, // R3 prefix overrides
      '{1'b0, 4'h0, 5'd15, 5'd5, 1'b1, 5'd3, 1'b1, 1'b1, 1'b0, 4'hB}, // R6
      '{1'b1, 4'hF, 5'd0,  5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 4'h0}, // R7
      '{1'b0, 4'h0, 5'd1,  5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 4'h0}  // R4 no source
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 0, in_ready, in_has_prefix = 0, in_rs1_used = 0, in_rs2_used = 0, in_mixed_ok = 0;
   logic [3:0] in_prefix_tag = '0;
   logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
   logic illegal_o, trap_enter = 0, trap_return = 0, clear_cmd = 0, csr_we = 0;
   logic [SEL_W-1:0] csr_sel = '0;
   logic [XLEN-1:0] csr_wdata = '0, csr_rdata;
   int n_chk = 0, n_bad = 0;
   logic done = 0;

   always #10 clk = ~clk;

   vmode_tag_tracker #(.NREG(NREG), .XLEN(XLEN)) u_vmode_tag_tracker (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_has_prefix(in_has_prefix), .in_prefix_tag(in_prefix_tag), .in_rd(in_rd),
      .in_rs1(in_rs1), .in_rs1_used(in_rs1_used), .in_rs2(in_rs2), .in_rs2_used(in_rs2_used),
      .in_mixed_ok(in_mixed_ok), .illegal_o(illegal_o), .trap_enter(trap_enter),
      .trap_return(trap_return), .clear_cmd(clear_cmd), .csr_sel(csr_sel), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic read_chunk(input int k, output logic [31:0] v);
      csr_sel = SEL_W'(k);
      #1 v = csr_rdata;
   endtask

   task automatic read_tag(input int r, output logic [3:0] t);
      logic [31:0] v;
      read_chunk((r * 4) / XLEN, v);
      t = v[((r * 4) % XLEN) +: 4];
   endtask

   task automatic write_chunk(input int k, input logic [31:0] d);
      @(negedge clk);
      csr_sel = SEL_W'(k); csr_wdata = d; csr_we = 1;
      @(negedge clk);
      csr_we = 0;
   endtask

   task automatic set_instr(input vec_t v);
      in_has_prefix = v.pre; in_prefix_tag = v.ptag; in_rd = v.rd;
      in_rs1 = v.rs1; in_rs1_used = v.u1; in_rs2 = v.rs2; in_rs2_used = v.u2;
      in_mixed_ok = v.mix; in_valid = 1;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: trap_enter = 1;
         1: trap_return = 1;
         default: clear_cmd = 1;
      endcase
      @(negedge clk);
      trap_enter = 0; trap_return = 0; clear_cmd = 0;
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [3:0] t;
      vec_t pv;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      read_chunk(0, v); check("R1 chunk0", v, 32'h0);
      read_chunk(3, v); check("R1 chunk3", v, 32'h0);
      check("R1 ready", {31'b0, in_ready}, 32'h1);
      check("R1 illegal", {31'b0, illegal_o}, 32'h0);

      write_chunk(0, 32'h06B9415F);
      read_chunk(0, v); check("R2 R7 chunk0 write", v, 32'h06B94150);
      read_tag(5, t);   check("R2 x5 position", {28'b0, t}, 32'hB);

      foreach (VECS[i]) begin
         @(negedge clk);
         set_instr(VECS[i]);
         @(negedge clk);
         in_valid = 0;
         check($sformatf("R5 illegal vec%0d", i), {31'b0, illegal_o}, {31'b0, VECS[i].exp_ill});
         read_tag(VECS[i].rd, t);
         check($sformatf("R3/R4/R6/R7/R12 tag vec%0d", i), {28'b0, t}, {28'b0, VECS[i].exp_tag});
      end
      read_chunk(1, v); check("R2 chunk1 layout", v, 32'hB361945E);
      read_chunk(0, v); check("R4 chunk0 after", v, 32'h06B94100);

      // R11: chunk write and instruction offered together
      pv = '{1'b1, 4'h7, 5'd9, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 4'h0};
      @(negedge clk);
      set_instr(pv); csr_sel = '0; csr_wdata = 32'h06B94100; csr_we = 1;
      #1 check("R11 ready low", {31'b0, in_ready}, 32'h0);
      @(negedge clk);
      in_valid = 0; csr_we = 0;
      read_tag(9, t); check("R11 x9 untouched", {28'b0, t}, 32'h5);

      pulse(0);
      read_chunk(0, v); check("R8 chunk0 cleared", v, 32'h0);
      read_chunk(1, v); check("R8 chunk1 cleared", v, 32'h0);
      pv = '{1'b1, 4'h7, 5'd8, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 4'h0};
      @(negedge clk); set_instr(pv);
      @(negedge clk); in_valid = 0;
      read_tag(8, t); check("R8 write in trap", {28'b0, t}, 32'h7);
      pulse(1);
      read_chunk(0, v); check("R9 chunk0 restored", v, 32'h06B94100);
      read_chunk(1, v); check("R9 chunk1 restored", v, 32'hB361945E);
      pulse(2);
      read_chunk(0, v); check("R10 chunk0 cleared", v, 32'h0);
      read_chunk(1, v); check("R10 chunk1 cleared", v, 32'h0);
      check("R5 illegal idle", {31'b0, illegal_o}, 32'h0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule